// File: doc/BRIEF.md
# Prioritised Nested Interrupt Controller

This block collects a vector of level-sensitive interrupt request lines and decides which of them a processor core should service next. Each line has an enable bit, a latched pending bit, an active bit and an 8-bit priority byte. A smaller priority number means higher precedence. Only the upper `PRIO_BITS` bits of each byte are stored. The controller presents at most one request to the core, using a request / acknowledge / return-from-handler handshake. It keeps a stack of the handlers the core has entered, so handlers can nest.

A programmable split point divides every priority byte into two fields. The upper field is the preemption group and the lower field is a sub-priority. Only the group field decides whether a new request may interrupt a running handler. The full byte orders pending requests against each other, and the line number settles any remaining tie.

Software reaches the block through a flat 32-bit register bus with a word address and byte-lane strobes. The bus provides:
- separate set and clear banks for the enables;
- one byte lane per line for the priorities;
- one word for the split point.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset all enables, pending and active bits are zero, every priority byte and the split field read as zero, and `irq_req` is low.
- R2: A write to set-enable word k (word address 0x00+k) sets the enable of line 32k+n for every 1 in data bit n and leaves lines under 0 bits unchanged; reading word 0x00+k or 0x08+k returns the current enable bits of lines 32k..32k+31.
- R3: A write to clear-enable word k (word address 0x08+k) clears the enable of line 32k+n for every 1 in data bit n and leaves lines under 0 bits unchanged; a line whose enable is cleared is no longer presented.
- R4: The priority of line i sits in byte lane i mod 4 (bits 8(i mod 4)+7 down to 8(i mod 4)) of word address 0x20 + i/4. A lane is written only when its strobe bit in `bus_be` is 1, only the top `PRIO_BITS` bits are kept, and the lower bits read as zero.
- R5: A line whose request input is high while it is not active becomes pending on the next clock edge, whether or not it is enabled, and stays pending after the request drops until it is acknowledged.
- R6: Among lines that are both pending and enabled, the one with the numerically smallest priority byte is selected and shown on `irq_id`; on equal bytes the lower line number wins.
- R7: Bits [2:0] of word address 0x10 hold the split point s. Priority bits [7:s] form the group field and bits [s-1:0] form the sub-priority.
- R8: `irq_req` is high only when the selected request's group field is numerically strictly smaller than the running priority. The running priority is the smallest group field among active handlers, or above every possible group when no handler is active.
- R9: When `irq_ack` is high with `irq_req` high and `irq_eret` low, the presented line leaves the pending state and becomes active at that clock edge.
- R10: When `irq_eret` is high, the most recently activated line that is still active is deactivated, and the running priority falls back to that of the remaining handlers.
- R11: A line whose request input is still high when it is deactivated becomes pending again one clock edge later.
- R12: `irq_ack` while `irq_req` is low, or while `irq_eret` is high, changes nothing; `irq_eret` with no active handler changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | NUM_LINES | Level request per line |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Word address for write and read |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte-lane strobes for writes |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_req | output | 1 | A request may be taken by the core |
| irq_id | output | ID_W | Line number of the presented request |
| irq_ack | input | 1 | Core takes the presented request |
| irq_eret | input | 1 | Core leaves its current handler |

## Verification
A corrupted pending, active or stack state does not stay hidden. It shows up within a cycle or two as one of three faults at the ports:
- `irq_req` is missing or spurious;
- `irq_id` names the wrong line after an acknowledge;
- the wrong handler is resumed after a return.

The bench drives the handshake through a nested sequence, so a stack that pops out of order makes the running priority wrong. That in turn changes whether the next request is presented, and the bench sees it on the next return. A mistake in group masking shows as a preemption that fires or is withheld when it should not be. The split point is changed while a handler is active so that this case is observed.

// File: rtl/nic_pkg.sv
package nic_pkg;

    typedef logic [7:0] prio_t;

    // Word addresses on the register bus
    localparam logic [7:0] A_SETEN = 8'h00;
    localparam logic [7:0] A_CLREN = 8'h08;
    localparam logic [7:0] A_SPLIT = 8'h10;
    localparam logic [7:0] A_PRIO  = 8'h20;

    typedef struct packed {
        logic        we;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [3:0]  be;
    } bus_wr_t;

    typedef struct packed {
        logic       valid;
        prio_t      prio;
        logic [7:0] line;
    } sel_t;

    // Keep only the preemption-group field of a priority byte
    function automatic prio_t group_of(prio_t p, logic [2:0] split);
        return p & (8'hFF << split);
    endfunction

endpackage

// File: rtl/nic_regs.sv
module nic_regs
    import nic_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int PRIO_BITS = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  bus_wr_t              wr,
    input  logic [7:0]           rd_addr,
    output logic [NUM_LINES-1:0] en,
    output prio_t                prio [NUM_LINES],
    output logic [2:0]           split,
    output logic [31:0]          rdata
);
    localparam int    EWORDS    = (NUM_LINES + 31) / 32;
    localparam int    PWORDS    = (NUM_LINES + 3) / 4;
    localparam prio_t IMPL_MASK = prio_t'(8'hFF << (8 - PRIO_BITS));

    logic [EWORDS*32-1:0] en_pad;
    logic [PWORDS*32-1:0] prio_pad;

    always_ff @(posedge clk) begin
        if (rst) begin
            en    <= '0;
            split <= '0;
            for (int i = 0; i < NUM_LINES; i++) prio[i] <= '0;
        end else if (wr.we) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                if (wr.addr == 8'(A_SETEN + i / 32) && wr.data[i % 32])
                    en[i] <= 1'b1;
                if (wr.addr == 8'(A_CLREN + i / 32) && wr.data[i % 32])
                    en[i] <= 1'b0;
                if (wr.addr == 8'(A_PRIO + i / 4) && wr.be[i % 4])
                    prio[i] <= wr.data[8*(i % 4) +: 8] & IMPL_MASK;
            end
            if (wr.addr == A_SPLIT && wr.be[0])
                split <= wr.data[2:0];
        end
    end

    // Zero-padded views for the word-wide read mux
    generate
        if (EWORDS * 32 > NUM_LINES) begin : g_en_pad
            assign en_pad = {{(EWORDS*32-NUM_LINES){1'b0}}, en};
        end else begin : g_en_full
            assign en_pad = en;
        end
        for (genvar p = 0; p < PWORDS * 4; p++) begin : g_prio_lane
            if (p < NUM_LINES) begin : g_used
                assign prio_pad[8*p +: 8] = prio[p];
            end else begin : g_spare
                assign prio_pad[8*p +: 8] = 8'h00;
            end
        end
    endgenerate

    always_comb begin
        rdata = '0;
        for (int w = 0; w < EWORDS; w++)
            if (rd_addr == 8'(A_SETEN + w) || rd_addr == 8'(A_CLREN + w))
                rdata = en_pad[32*w +: 32];
        for (int w = 0; w < PWORDS; w++)
            if (rd_addr == 8'(A_PRIO + w))
                rdata = prio_pad[32*w +: 32];
        if (rd_addr == A_SPLIT)
            rdata = {29'b0, split};
    end

endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter
    import nic_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input  logic [NUM_LINES-1:0] cand,
    input  prio_t                prio [NUM_LINES],
    output sel_t                 sel
);
    // Ascending scan: strict less-than keeps the lower line on a tie
    always_comb begin
        sel = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (cand[i] && (!sel.valid || prio[i] < sel.prio)) begin
                sel.valid = 1'b1;
                sel.prio  = prio[i];
                sel.line  = 8'(i);
            end
        end
    end

endmodule

// File: rtl/nic_stack.sv
module nic_stack #(
    parameter int NUM_LINES = 8,
    parameter int ID_W      = 3,
    parameter int DW        = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 push,
    input  logic [ID_W-1:0]      push_line,
    input  logic                 pop,
    output logic [NUM_LINES-1:0] act,
    output logic [DW-1:0]        depth
);
    localparam int IW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

    logic [ID_W-1:0] stk [NUM_LINES];
    logic [IW-1:0]   top_idx;
    logic [IW-1:0]   free_idx;

    assign top_idx  = IW'(depth - 1'b1);
    assign free_idx = IW'(depth);

    always_ff @(posedge clk) begin
        if (rst) begin
            act   <= '0;
            depth <= '0;
            for (int i = 0; i < NUM_LINES; i++) stk[i] <= '0;
        end else if (pop) begin
            if (depth != '0) begin
                act[stk[top_idx]] <= 1'b0;
                depth             <= depth - 1'b1;
            end
        end else if (push) begin
            stk[free_idx]  <= push_line;
            act[push_line] <= 1'b1;
            depth          <= depth + 1'b1;
        end
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import nic_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int PRIO_BITS = 3,
    localparam int ID_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_lines,
    input  logic                 bus_we,
    input  logic [7:0]           bus_addr,
    input  logic [31:0]          bus_wdata,
    input  logic [3:0]           bus_be,
    output logic [31:0]          bus_rdata,
    output logic                 irq_req,
    output logic [ID_W-1:0]      irq_id,
    input  logic                 irq_ack,
    input  logic                 irq_eret
);
    localparam int DW = $clog2(NUM_LINES + 1);

    bus_wr_t              wr;
    logic [NUM_LINES-1:0] en_q;
    logic [NUM_LINES-1:0] pend_q;
    logic [NUM_LINES-1:0] act_q;
    logic [DW-1:0]        depth_q;
    prio_t                prio_q [NUM_LINES];
    logic [2:0]           split_q;
    sel_t                 sel;
    logic [8:0]           run_prio;
    logic                 ack_go;

    assign wr = '{we: bus_we, addr: bus_addr, data: bus_wdata, be: bus_be};

    nic_regs #(.NUM_LINES(NUM_LINES), .PRIO_BITS(PRIO_BITS)) u_regs (
        .clk(clk), .rst(rst), .wr(wr), .rd_addr(bus_addr),
        .en(en_q), .prio(prio_q), .split(split_q), .rdata(bus_rdata)
    );

    nic_arbiter #(.NUM_LINES(NUM_LINES)) u_arb (
        .cand(pend_q & en_q), .prio(prio_q), .sel(sel)
    );

    // Running priority: smallest group among active handlers, 9'h100 when idle
    always_comb begin
        run_prio = 9'h100;
        for (int i = 0; i < NUM_LINES; i++)
            if (act_q[i] && {1'b0, group_of(prio_q[i], split_q)} < run_prio)
                run_prio = {1'b0, group_of(prio_q[i], split_q)};
    end

    assign irq_req = sel.valid && ({1'b0, group_of(sel.prio, split_q)} < run_prio);
    assign irq_id  = sel.line[ID_W-1:0];
    assign ack_go  = irq_ack && irq_req && !irq_eret;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            for (int i = 0; i < NUM_LINES; i++) begin
                if (ack_go && irq_id == ID_W'(i))
                    pend_q[i] <= 1'b0;
                else if (irq_lines[i] && !act_q[i])
                    pend_q[i] <= 1'b1;
            end
        end
    end

    nic_stack #(.NUM_LINES(NUM_LINES), .ID_W(ID_W), .DW(DW)) u_stack (
        .clk(clk), .rst(rst), .push(ack_go), .push_line(irq_id),
        .pop(irq_eret), .act(act_q), .depth(depth_q)
    );

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
    parameter int NUM_LINES = 8,
    parameter int ID_W      = 3,
    parameter int DW        = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 irq_req,
    input logic [ID_W-1:0]      irq_id,
    input logic                 irq_ack,
    input logic                 irq_eret,
    input logic [NUM_LINES-1:0] pend,
    input logic [NUM_LINES-1:0] en,
    input logic [NUM_LINES-1:0] act,
    input logic [DW-1:0]        depth
);
    a_r6_sel_is_candidate: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (pend[irq_id] && en[irq_id]));

    a_r9_ack_activates: assert property (@(posedge clk) disable iff (rst)
        (irq_req && irq_ack && !irq_eret) |=> (act[$past(irq_id)] && !pend[$past(irq_id)]));

    a_r5_pend_act_disjoint: assert property (@(posedge clk) disable iff (rst)
        (pend & act) == '0);

    a_r10_depth_tracks_active: assert property (@(posedge clk) disable iff (rst)
        depth == DW'($countones(act)));

    a_r12_empty_return: assert property (@(posedge clk) disable iff (rst)
        (irq_eret && depth == '0) |=> (depth == '0));

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NUM_LINES(NUM_LINES), .ID_W(ID_W), .DW(DW)) u_chk (
    .clk(clk), .rst(rst), .irq_req(irq_req), .irq_id(irq_id),
    .irq_ack(irq_ack), .irq_eret(irq_eret), .pend(pend_q), .en(en_q),
    .act(act_q), .depth(depth_q)
);

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] irq_lines = '0;
    logic         bus_we = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [3:0]   bus_be = '0;
    logic [31:0]  bus_rdata;
    logic         irq_req;
    logic [2:0]   irq_id;
    logic         irq_ack = 1'b0;
    logic         irq_eret = 1'b0;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    prio_irq_ctrl #(.NUM_LINES(N), .PRIO_BITS(3)) u0 (
        .clk(clk), .rst(rst), .irq_lines(irq_lines), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
        .bus_rdata(bus_rdata), .irq_req(irq_req), .irq_id(irq_id),
        .irq_ack(irq_ack), .irq_eret(irq_eret)
    );

    // Priority-lane vectors: address, strobes, write data, expected readback (R4)
    localparam logic [7:0]  TV_ADDR [6] = '{8'h20, 8'h20, 8'h20, 8'h20, 8'h21, 8'h21};
    localparam logic [3:0]  TV_BE   [6] = '{4'hF, 4'h3, 4'hC, 4'h1, 4'hF, 4'h0};
    localparam logic [31:0] TV_DATA [6] = '{32'hFF7F3F1F, 32'h12344159, 32'h9F5F0000,
                                            32'h0000007F, 32'hFF1FC03F, 32'hFFFFFFFF};
    localparam logic [31:0] TV_EXP  [6] = '{32'hE0602000, 32'hE0604040, 32'h80404040,
                                            32'h80404060, 32'hE000C020, 32'hE000C020};

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check_eq(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic check_irq(string tag, logic exp_req, logic [2:0] exp_id);
        check_eq(tag, {31'b0, irq_req}, {31'b0, exp_req});
        if (exp_req) check_eq(tag, {29'b0, irq_id}, {29'b0, exp_id});
    endtask

    task automatic bus_write(logic [7:0] a, logic [31:0] d, logic [3:0] be);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        tick();
        bus_we = 1'b0; bus_be = '0;
    endtask

    task automatic bus_read(string tag, logic [7:0] a, logic [31:0] exp);
        bus_addr = a;
        #1;
        check_eq(tag, bus_rdata, exp);
    endtask

    task automatic pulse_ack();
        irq_ack = 1'b1; tick(); irq_ack = 1'b0;
    endtask

    task automatic pulse_eret();
        irq_eret = 1'b1; tick(); irq_eret = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1: reset state
        check_irq("R1 idle", 1'b0, 3'd0);
        bus_read("R1 enables", 8'h00, 32'h0);
        bus_read("R1 prio", 8'h20, 32'h0);
        bus_read("R1 split", 8'h10, 32'h0);

        // R2 / R3: enable banks
        bus_write(8'h00, 32'h0000000F, 4'hF);
        bus_read("R2 set bank", 8'h00, 32'h0F);
        bus_read("R2 clear bank read", 8'h08, 32'h0F);
        bus_write(8'h00, 32'h00000030, 4'hF);
        bus_read("R2 zero bits kept", 8'h00, 32'h3F);
        bus_write(8'h08, 32'h00000005, 4'hF);
        bus_read("R3 clear", 8'h00, 32'h3A);

        // R4: priority lanes, table walk
        for (int v = 0; v < 6; v++) begin
            bus_write(TV_ADDR[v], TV_DATA[v], TV_BE[v]);
            bus_read("R4 lane", TV_ADDR[v], TV_EXP[v]);
        end
        // prio: L0=60 L1=40 L2=40 L3=80 L4=20 L5=C0 L6=00 L7=E0; enabled 1,3,4,5

        // R5 / R6: pending and selection, disabled line 6 ignored
        irq_lines = 8'b0100_1000;
        tick();
        check_irq("R6 single enabled", 1'b1, 3'd3);
        irq_lines = 8'b0100_1010;
        tick();
        check_irq("R6 lower byte wins", 1'b1, 3'd1);
        irq_lines = 8'b0100_1110;
        bus_write(8'h00, 32'h04, 4'hF);
        check_irq("R6 tie lower line", 1'b1, 3'd1);
        irq_lines = '0;
        tick();
        check_irq("R5 latched after drop", 1'b1, 3'd1);

        // R9 / R8: take line 1, equal group does not preempt
        pulse_ack();
        check_irq("R8 equal group blocked", 1'b0, 3'd0);

        // R7: split 7 makes L4 (0x20) share group with L1 (0x40)
        bus_write(8'h10, 32'h7, 4'h1);
        irq_lines[4] = 1'b1;
        tick();
        check_irq("R7 sub-priority no preempt", 1'b0, 3'd0);
        bus_write(8'h10, 32'h0, 4'h1);
        check_irq("R8 lower group preempts", 1'b1, 3'd4);

        // R9: nested take of line 4, request kept high
        pulse_ack();
        check_irq("R9 nested taken", 1'b0, 3'd0);
        tick();
        check_irq("R9 active not repended", 1'b0, 3'd0);

        // R11: return from line 4 with request still high
        pulse_eret();
        check_irq("R11 not yet pending", 1'b0, 3'd0);
        tick();
        check_irq("R11 pending again", 1'b1, 3'd4);
        irq_lines[4] = 1'b0;
        pulse_ack();
        pulse_eret();
        check_irq("R10 back in line 1", 1'b0, 3'd0);

        // R10: returning from line 1 unblocks line 2
        pulse_eret();
        check_irq("R10 stack empty", 1'b1, 3'd2);

        // R3: disabling line 2 moves selection to line 3
        bus_write(8'h08, 32'h04, 4'hF);
        check_irq("R3 disabled dropped", 1'b1, 3'd3);

        // R12: spurious handshakes
        pulse_ack();
        check_irq("R12 line 3 active", 1'b0, 3'd0);
        pulse_eret();
        pulse_eret();
        check_irq("R12 empty return", 1'b0, 3'd0);
        pulse_ack();
        bus_write(8'h00, 32'h04, 4'hF);
        check_irq("R12 stray ack ignored", 1'b1, 3'd2);
        bus_write(8'h00, 32'h40, 4'hF);
        check_irq("R6 priority zero wins", 1'b1, 3'd6);
        irq_ack = 1'b1; irq_eret = 1'b1;
        tick();
        irq_ack = 1'b0; irq_eret = 1'b0;
        check_irq("R12 ack with return ignored", 1'b1, 3'd6);
        pulse_ack();
        check_irq("R8 top priority active", 1'b0, 3'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule